// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block is a synthesizable device-side stand-in for a two-bank synchronous DRAM. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins into a command. It keeps an open or closed flag and the latched row for each bank, and it holds 16-bit words in a small internal array addressed by bank, row and column. A memory controller under test connects to it in place of a real device. The block then answers reads with stored data, and it flags accesses that break the open-bank protocol.

The top address bit has two meanings. On an access it requests that the bank close once the access completes. On a precharge it widens the close to every bank. The two byte masks act at different times: a write mask blocks the store in the cycle it is sampled, while a read mask blanks the output byte two cycles after it is sampled. Read data comes back after a parameterised CAS latency, and the mask delay is fixed at two cycles regardless of that latency. The array keeps only a few row and column bits per bank, and the remaining address bits are XOR-folded into that index.

Top module: `sdram_cmd_model`

## Requirements
- R1: While `cs_n` is high at a clock edge, that edge's pins cause no command: bank state, stored data and the error flag are unchanged.
- R2: When `cke` is low at edge e, the command on the pins at edge e+1 is ignored.
- R3: Pin codes {ras_n,cas_n,we_n} are: 011 activate, 101 read, 100 write, 010 precharge. Every other code is a no-operation. An activate stores `addr` (all 9 bits) as the open row of the bank named by `bank_sel` and marks that bank open.
- R4: A write to an open bank stores `dq_in` at the bank's open row and the column `addr[7:0]` in the same edge. `byte_mask[0]` high keeps bits 7:0 from being stored, and `byte_mask[1]` high keeps bits 15:8 from being stored.
- R5: A read to an open bank issued at edge k drives the stored word on `dq_out` with `dq_oe`=2'b11 for sampling at edge k+CAS_LAT (default 2). At every other time `dq_oe` is 2'b00.
- R6: `byte_mask[i]` sampled high at edge j forces `dq_oe[i]` low and the matching byte of `dq_out` to zero for the output sampled at edge j+2.
- R7: A read or write with `addr[8]` high closes the addressed bank after the access completes.
- R8: A precharge with `addr[8]` high closes all banks. With `addr[8]` low it closes only the bank named by `bank_sel`.
- R9: A read or write to a closed bank, or an activate to an open bank, sets `err_flag` at the next edge. The flag stays set until reset. The failed access stores nothing and drives no data.
- R10: Reset closes all banks, clears the array and the error flag, and holds `dq_oe` at 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suppresses the next edge's command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| bank_sel | input | 1 | Bank addressed by the command |
| addr | input | 9 | Row (activate), column in bits 7:0 plus close flag in bit 8 (access), all-bank flag in bit 8 (precharge) |
| byte_mask | input | 2 | Per-byte write block / delayed read blank |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, masked bytes zero |
| dq_oe | output | 2 | Per-byte read output enable |
| err_flag | output | 1 | Sticky protocol error |

## Verification
On every cycle, the assertions hold the following: chip-select-high cycles leave the bank flags alone, a cke-low edge freezes the banks two edges later, an all-bank precharge leaves every bank closed, and any protocol breach sets the error flag, which never falls again. They also tie each delayed read mask to its blanked byte and keep disabled bytes at zero. Only the bench scenarios can show the data itself: that masked writes keep the old byte, that reads return the word at the right row and CAS latency, that auto-close on a read and on a write leaves the bank ready for a fresh activate, and that a rejected write leaves the array untouched.

// File: rtl/sdram_model_pkg.sv
`timescale 1ns/1ps
package sdram_model_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4
  } cmd_e;

  // Read output-disable lag, independent of CAS latency
  localparam int unsigned RMASK_LAT = 2;

  function automatic cmd_e pin_decode(input logic ras_n, input logic cas_n,
                                      input logic we_n);
    cmd_e c;
    case ({ras_n, cas_n, we_n})
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_READ;
      3'b100:  c = CMD_WRITE;
      3'b010:  c = CMD_PRE;
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

  // XOR-fold a wide address into 'keep' index bits
  function automatic logic [31:0] fold_bits(input logic [31:0] v,
                                            input int unsigned keep);
    logic [31:0] acc;
    acc = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      acc[i % keep] = acc[i % keep] ^ v[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
  import sdram_model_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  logic cke_q;
  logic gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign gate_open = cke_q & ~cs_n;
  assign cmd       = gate_open ? pin_decode(ras_n, cas_n, we_n) : CMD_NONE;

endmodule

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
module sdram_bank_tracker
  import sdram_model_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  parameter  int ROW_W     = 9,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic [ROW_W-1:0]     addr,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [ROW_W-1:0]     sel_row,
  output logic                 access_ok,
  output logic                 access_bad,
  output logic                 act_bad
);

  localparam int AP_BIT = ROW_W - 1;

  logic [ROW_W-1:0] row_q [NUM_BANKS];
  logic             is_access;
  logic             wide_flag;

  assign is_access = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign wide_flag = addr[AP_BIT];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit_b;
    logic             open_b;
    logic [ROW_W-1:0] row_b;

    assign hit_b = (bank == BA_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_b <= 1'b0;
        row_b  <= '0;
      end else begin
        case (cmd)
          CMD_ACT: begin
            if (hit_b) begin
              open_b <= 1'b1;
              row_b  <= addr;
            end
          end
          CMD_READ, CMD_WRITE: begin
            if (hit_b && wide_flag) open_b <= 1'b0;
          end
          CMD_PRE: begin
            if (hit_b || wide_flag) open_b <= 1'b0;
          end
          default: ;
        endcase
      end
    end

    assign bank_open[b] = open_b;
    assign row_q[b]     = row_b;
  end

  assign sel_row    = row_q[bank];
  assign access_ok  = is_access &  bank_open[bank];
  assign access_bad = is_access & ~bank_open[bank];
  assign act_bad    = (cmd == CMD_ACT) & bank_open[bank];

endmodule

// File: rtl/sdram_data_store.sv
`timescale 1ns/1ps
module sdram_data_store
  import sdram_model_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  parameter  int ROW_W     = 9,
  parameter  int COL_W     = 8,
  parameter  int ROW_KEEP  = 2,
  parameter  int COL_KEEP  = 3,
  parameter  int DQ_BYTES  = 2,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int DQ_W      = 8 * DQ_BYTES,
  localparam int IDX_W     = BA_W + ROW_KEEP + COL_KEEP,
  localparam int DEPTH     = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BA_W-1:0]     bank,
  input  logic [ROW_W-1:0]    row,
  input  logic [COL_W-1:0]    col,
  input  logic [DQ_W-1:0]     wdata,
  input  logic [DQ_BYTES-1:0] wmask,
  output logic [DQ_W-1:0]     rdata
);

  logic [ROW_KEEP-1:0] row_idx;
  logic [COL_KEEP-1:0] col_idx;
  logic [IDX_W-1:0]    idx;
  logic [DQ_W-1:0]     mem [DEPTH];

  assign row_idx = ROW_KEEP'(fold_bits(32'(row), ROW_KEEP));
  assign col_idx = COL_KEEP'(fold_bits(32'(col), COL_KEEP));
  assign idx     = {bank, row_idx, col_idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < DQ_BYTES; i++) begin
        if (!wmask[i]) mem[idx][8*i +: 8] <= wdata[8*i +: 8];
      end
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/sdram_read_pipe.sv
`timescale 1ns/1ps
module sdram_read_pipe
  import sdram_model_pkg::*;
#(
  parameter  int CAS_LAT  = 2,
  parameter  int DQ_BYTES = 2,
  localparam int DQ_W     = 8 * DQ_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_fire,
  input  logic [DQ_W-1:0]     rdata,
  input  logic [DQ_BYTES-1:0] byte_mask,
  output logic [DQ_W-1:0]     dq_out,
  output logic [DQ_BYTES-1:0] dq_oe
);

  logic [CAS_LAT-1:0]  vld_q;
  logic [DQ_W-1:0]     dat_q [CAS_LAT];
  logic [DQ_BYTES-1:0] msk_q [RMASK_LAT];
  logic                lat_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < CAS_LAT; i++)        dat_q[i] <= '0;
      for (int i = 0; i < int'(RMASK_LAT); i++) msk_q[i] <= '0;
    end else begin
      vld_q[0] <= rd_fire;
      dat_q[0] <= rdata;
      for (int i = 1; i < CAS_LAT; i++) begin
        vld_q[i] <= vld_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
      msk_q[0] <= byte_mask;
      for (int i = 1; i < int'(RMASK_LAT); i++) msk_q[i] <= msk_q[i-1];
    end
  end

  assign lat_valid = vld_q[CAS_LAT-1];

  for (genvar i = 0; i < DQ_BYTES; i++) begin : g_lane
    assign dq_oe[i]         = lat_valid & ~msk_q[RMASK_LAT-1][i];
    assign dq_out[8*i +: 8] = dq_oe[i] ? dat_q[CAS_LAT-1][8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/sdram_cmd_model.sv
`timescale 1ns/1ps
module sdram_cmd_model
  import sdram_model_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  parameter  int ROW_W     = 9,
  parameter  int CAS_LAT   = 2,
  parameter  int ROW_KEEP  = 2,
  parameter  int COL_KEEP  = 3,
  parameter  int DQ_BYTES  = 2,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int COL_W     = ROW_W - 1,
  localparam int DQ_W      = 8 * DQ_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BA_W-1:0]     bank_sel,
  input  logic [ROW_W-1:0]    addr,
  input  logic [DQ_BYTES-1:0] byte_mask,
  input  logic [DQ_W-1:0]     dq_in,
  output logic [DQ_W-1:0]     dq_out,
  output logic [DQ_BYTES-1:0] dq_oe,
  output logic                err_flag
);

  cmd_e                 cmd_w;
  logic [NUM_BANKS-1:0] bank_open;
  logic [ROW_W-1:0]     sel_row;
  logic                 access_ok;
  logic                 access_bad;
  logic                 act_bad;
  logic                 rd_fire;
  logic                 wr_fire;
  logic [DQ_W-1:0]      rdata_w;
  logic                 err_q;

  sdram_cmd_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_w)
  );

  sdram_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd_w),
    .bank       (bank_sel),
    .addr       (addr),
    .bank_open  (bank_open),
    .sel_row    (sel_row),
    .access_ok  (access_ok),
    .access_bad (access_bad),
    .act_bad    (act_bad)
  );

  assign rd_fire = access_ok & (cmd_w == CMD_READ);
  assign wr_fire = access_ok & (cmd_w == CMD_WRITE);

  sdram_data_store #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .ROW_KEEP  (ROW_KEEP),
    .COL_KEEP  (COL_KEEP),
    .DQ_BYTES  (DQ_BYTES)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_fire),
    .bank  (bank_sel),
    .row   (sel_row),
    .col   (addr[COL_W-1:0]),
    .wdata (dq_in),
    .wmask (byte_mask),
    .rdata (rdata_w)
  );

  sdram_read_pipe #(
    .CAS_LAT  (CAS_LAT),
    .DQ_BYTES (DQ_BYTES)
  ) u_rpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rdata     (rdata_w),
    .byte_mask (byte_mask),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      err_q <= 1'b0;
    else if (access_bad || act_bad)  err_q <= 1'b1;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/sdram_cmd_model_chk.sv
`timescale 1ns/1ps
module sdram_cmd_model_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 9,
  parameter int DQ_BYTES  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [ROW_W-1:0]     addr,
  input logic [DQ_BYTES-1:0]  byte_mask,
  input logic [8*DQ_BYTES-1:0] dq_out,
  input logic [DQ_BYTES-1:0]  dq_oe,
  input logic                 err_flag,
  input logic                 access_bad,
  input logic                 act_bad,
  input logic [NUM_BANKS-1:0] bank_open
);

  // R1
  cs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(bank_open));

  // R2
  cke_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ##2 $stable(bank_open));

  // R8
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && !cs_n && ({ras_n, cas_n, we_n} == 3'b010) && addr[ROW_W-1])
    |=> (bank_open == '0));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_bad || act_bad) |=> err_flag);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  for (genvar i = 0; i < DQ_BYTES; i++) begin : g_lane_chk
    // R6
    rmask_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(byte_mask[i], 2) |-> !dq_oe[i]);

    // R6
    blank_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[i] |-> (dq_out[8*i +: 8] == 8'h00));
  end

endmodule

bind sdram_cmd_model sdram_cmd_model_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .DQ_BYTES  (DQ_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .addr       (addr),
  .byte_mask  (byte_mask),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .err_flag   (err_flag),
  .access_bad (access_bad),
  .act_bad    (act_bad),
  .bank_open  (bank_open)
);

// File: tb/sim_sdram_cmd_model.sv
`timescale 1ns/1ps
module sim_sdram_cmd_model;

  localparam int CL = 2;
  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_NOP = 3'b111;

  logic        clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [0:0]  bank_sel = '0;
  logic [8:0]  addr = '0;
  logic [1:0]  byte_mask = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        err_flag;

  sdram_cmd_model u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
    .byte_mask(byte_mask), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .err_flag(err_flag)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { int due; logic [15:0] data; logic [1:0] oe; string tag; } exp_t;
  exp_t q[$];
  logic [15:0] model [logic [17:0]];
  logic [8:0]  brow [2];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pins(input logic [2:0] rcw, input logic b, input logic [8:0] a,
                      input logic [15:0] d, input logic [1:0] m,
                      input logic csn, input logic ck);
    {ras_n, cas_n, we_n} = rcw;
    bank_sel = b; addr = a; dq_in = d; byte_mask = m; cs_n = csn; cke = ck;
    @(negedge clk);
    {ras_n, cas_n, we_n} = P_NOP;
    byte_mask = '0; cs_n = 1'b0; cke = 1'b1; addr = '0; dq_in = '0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) pins(P_NOP, 1'b0, 9'h0, 16'h0, 2'b00, 1'b0, 1'b1);
  endtask

  task automatic act(input logic b, input logic [8:0] row);
    brow[b] = row;
    pins(P_ACT, b, row, 16'h0, 2'b00, 1'b0, 1'b1);
  endtask

  task automatic pre(input logic b, input logic all);
    pins(P_PRE, b, {all, 8'h00}, 16'h0, 2'b00, 1'b0, 1'b1);
  endtask

  task automatic wr(input logic b, input logic [7:0] col, input logic [15:0] d,
                    input logic [1:0] m, input logic ap, input bit stored);
    logic [17:0] key;
    logic [15:0] cur;
    key = {b, brow[b], col};
    if (stored) begin
      cur = model.exists(key) ? model[key] : 16'h0;
      for (int i = 0; i < 2; i++) if (!m[i]) cur[8*i +: 8] = d[8*i +: 8];
      model[key] = cur;
    end
    pins(P_WR, b, {ap, col}, d, m, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic b, input logic [7:0] col, input logic [1:0] m,
                    input logic ap, input string tag);
    logic [17:0] key;
    exp_t e;
    key = {b, brow[b], col};
    e.data = model.exists(key) ? model[key] : 16'h0;
    e.oe = ~m;
    for (int i = 0; i < 2; i++) if (m[i]) e.data[8*i +: 8] = 8'h00;
    e.due = cyc + CL;
    e.tag = tag;
    q.push_back(e);
    pins(P_RD, b, {ap, col}, 16'h0, m, 1'b0, 1'b1);
  endtask

  task automatic chk_err(input logic exp, input string tag);
    check(err_flag == exp, tag, "err_flag", 32'(err_flag), 32'(exp));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Monitor: pops expected read items when due, else expects silence (R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(dq_oe == e.oe, e.tag, "dq_oe", 32'(dq_oe), 32'(e.oe));
        check(dq_out == e.data, e.tag, "dq_out", 32'(dq_out), 32'(e.data));
      end else begin
        check(dq_oe == 2'b00, "R5", "idle dq_oe", 32'(dq_oe), 32'h0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(dq_oe == 2'b00, "R10", "reset dq_oe", 32'(dq_oe), 32'h0);
    chk_err(1'b0, "R10");
    cs_n = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R4: open banks, plain and masked writes
    act(1'b0, 9'd1);
    act(1'b1, 9'd2);
    wr(1'b0, 8'd3, 16'hA5A5, 2'b00, 1'b0, 1'b1);
    wr(1'b1, 8'd3, 16'h1234, 2'b00, 1'b0, 1'b1);
    wr(1'b0, 8'd4, 16'hFFFF, 2'b01, 1'b0, 1'b1);
    wr(1'b0, 8'd5, 16'hBEEF, 2'b10, 1'b0, 1'b1);

    // R5 / R4 / R6: back-to-back reads, with lane masks
    rd(1'b0, 8'd3, 2'b00, 1'b0, "R5");
    rd(1'b1, 8'd3, 2'b00, 1'b0, "R5");
    rd(1'b0, 8'd4, 2'b00, 1'b0, "R4");
    rd(1'b0, 8'd5, 2'b00, 1'b0, "R4");
    rd(1'b0, 8'd3, 2'b10, 1'b0, "R6");
    rd(1'b0, 8'd3, 2'b01, 1'b0, "R6");
    nop(3);
    chk_err(1'b0, "R5");

    // R1: all-bank precharge with chip select high is ignored
    pins(P_PRE, 1'b0, 9'h100, 16'h0, 2'b00, 1'b1, 1'b1);
    rd(1'b0, 8'd3, 2'b00, 1'b0, "R1");
    nop(3);
    chk_err(1'b0, "R1");

    // R2: cke low, then an all-bank precharge on the next edge is ignored
    pins(P_NOP, 1'b0, 9'h0, 16'h0, 2'b00, 1'b0, 1'b0);
    pins(P_PRE, 1'b0, 9'h100, 16'h0, 2'b00, 1'b0, 1'b1);
    rd(1'b1, 8'd3, 2'b00, 1'b0, "R2");
    nop(3);
    chk_err(1'b0, "R2");

    // R8: single-bank precharge leaves the other bank open
    pre(1'b0, 1'b0);
    rd(1'b1, 8'd3, 2'b00, 1'b0, "R8");
    act(1'b0, 9'd1);   // would flag an error if bank 0 stayed open
    nop(3);
    chk_err(1'b0, "R8");

    // R7: auto-close on read, then on write
    rd(1'b1, 8'd3, 2'b00, 1'b1, "R7");
    act(1'b1, 9'd2);
    chk_err(1'b0, "R7");
    wr(1'b1, 8'd7, 16'h0F0F, 2'b00, 1'b1, 1'b1);
    act(1'b1, 9'd2);
    chk_err(1'b0, "R7");
    rd(1'b1, 8'd7, 2'b00, 1'b0, "R7");
    nop(3);

    // R3: another row of the same bank holds different data
    pre(1'b0, 1'b0);
    act(1'b0, 9'd2);
    rd(1'b0, 8'd3, 2'b00, 1'b0, "R3");
    nop(3);

    // R8: all-bank precharge closes both banks
    pre(1'b0, 1'b1);
    act(1'b0, 9'd1);
    act(1'b1, 9'd2);
    nop(1);
    chk_err(1'b0, "R8");

    // R9: write to a closed bank sets the flag and stores nothing
    pre(1'b0, 1'b1);
    wr(1'b0, 8'd6, 16'h5555, 2'b00, 1'b0, 1'b0);
    chk_err(1'b1, "R9");
    // R9: read of a closed bank drives no data (monitor expects dq_oe=0)
    pins(P_RD, 1'b0, 9'd3, 16'h0, 2'b00, 1'b0, 1'b1);
    nop(3);
    act(1'b0, 9'd1);
    rd(1'b0, 8'd6, 2'b00, 1'b0, "R9");
    nop(4);
    chk_err(1'b1, "R9");
    check(q.size() == 0, "R5", "pending reads", 32'(q.size()), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule